// File: doc/BRIEF.md
# Interleaved SRAM Audio Delay Line

This block turns one external asynchronous SRAM with a shared bidirectional data bus into a delay line for a stream of audio words. Each time a new sample arrives on the strobe, the block starts a fixed access sequence. It first stores the new word at the write pointer. It then releases the bus, waits a turnaround gap, and fetches the word stored a selectable number of samples earlier. That word is presented at the output together with a one-cycle valid pulse.

The separation between the two pointers is the delay. The delay is sampled on each strobe, so a change made between strobes takes effect at the next sample. Until enough samples have been stored to cover the requested delay, the output is forced to zero, so stale memory contents never reach the output. The memory depth can be any value of two words or more. A power-of-two depth wraps by plain binary overflow. Any other depth wraps by compare.

Top module: `audio_delay_sram`

## Requirements
- R1: While reset is held and after its release, before any sample strobe: sram_ce_n, sram_we_n and sram_oe_n are 1, out_valid is 0 and out_sample is 0.
- R2: For the n-th accepted sample (n counted from 0 after reset), sram_we_n is low for exactly WE_CYC consecutive cycles. During that time sram_ce_n is low, sram_addr equals n mod DEPTH, and sram_dq carries the sample word.
- R3: After the write, sram_oe_n is low for exactly RD_CYC consecutive cycles. During that time sram_addr equals (n - D) mod DEPTH, where D is the effective delay of that sample.
- R4: sram_oe_n is never low in a cycle where sram_we_n is low. At least TURN_CYC+1 cycles with both strobes high separate the last write-enable cycle from the first output-enable cycle. The block does not drive sram_dq while sram_oe_n is low.
- R5: For each accepted sample, out_valid is high for exactly one cycle, directly after the read phase. When not muted, out_sample then equals the input word of sample n - D.
- R6: When fewer than D samples were stored before sample n, out_sample is 0 at that sample's valid pulse.
- R7: The delay input is captured only at an accepted strobe. Changes to dly_set during a sequence do not affect it. A captured value above DEPTH-1 is treated as DEPTH-1.
- R8: A strobe that arrives while an access sequence is running is ignored. It neither writes memory nor advances the sample count.
- R9: With a depth that is not a power of two, both addresses stay below DEPTH and wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe: a new sample is present |
| smp_in | input | DATA_W | Sample word, taken with the strobe |
| dly_set | input | ADDR_W | Requested delay in samples |
| out_sample | output | DATA_W | Delayed sample word (zero while muted) |
| out_valid | output | 1 | One-cycle pulse when out_sample is updated |
| sram_addr | output | ADDR_W | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_dq | inout | DATA_W | Shared SRAM data bus |

## Verification
A write pointer that slips shows up at once as a wrong write address. It also shows up D samples later as an output word taken from the wrong sample. A bad delay capture or a bad modulo subtraction appears at the first read address after the change, and again at the same sample's valid pulse. A wrong fill count shows up as zeros where data was expected, or as data where zeros were expected, within the first D samples after reset. A sequencer fault shows within one sample period as wrong strobe widths, a missing turnaround gap, or extra or missing valid pulses.

// File: rtl/adly_pkg.sv
package adly_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WSET,
      PH_WPUL,
      PH_WHLD,
      PH_TURN,
      PH_RACC
   } phase_t;
endpackage

// File: rtl/adly_seq.sv
module adly_seq
   import adly_pkg::*;
#(
   parameter int WE_CYC   = 2,
   parameter int TURN_CYC = 1,
   parameter int RD_CYC   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   output logic start,
   output logic cap,
   output logic ce_n,
   output logic we_n,
   output logic oe_n,
   output logic drive_en,
   output logic sel_rd
);
   localparam int MAXC1 = (WE_CYC > TURN_CYC) ? WE_CYC : TURN_CYC;
   localparam int MAXC  = (MAXC1 > RD_CYC) ? MAXC1 : RD_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] TN_LAST = CNT_W'(TURN_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);

   phase_t ph;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (smp_valid) ph <= PH_WSET;
            PH_WSET: begin
               ph  <= PH_WPUL;
               cnt <= '0;
            end
            PH_WPUL: begin
               if (cnt == WE_LAST) begin
                  ph  <= PH_WHLD;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_WHLD: begin
               ph  <= PH_TURN;
               cnt <= '0;
            end
            PH_TURN: begin
               if (cnt == TN_LAST) begin
                  ph  <= PH_RACC;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_RACC: begin
               if (cnt == RD_LAST) begin
                  ph  <= PH_IDLE;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      start    = (ph == PH_IDLE) && smp_valid;
      cap      = (ph == PH_RACC) && (cnt == RD_LAST);
      ce_n     = !(ph == PH_WSET || ph == PH_WPUL || ph == PH_WHLD || ph == PH_RACC);
      we_n     = (ph != PH_WPUL);
      oe_n     = (ph != PH_RACC);
      drive_en = (ph == PH_WSET || ph == PH_WPUL || ph == PH_WHLD);
      sel_rd   = (ph == PH_TURN || ph == PH_RACC);
   end

   // R4
   oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> ($past(!drive_en) && $past(we_n)));
   // R4
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (!drive_en && we_n));
   // R2
   we_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce_n && drive_en));
endmodule

// File: rtl/adly_ptr.sv
module adly_ptr #(
   parameter int DEPTH  = 262144,
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              adv,
   input  logic [ADDR_W-1:0] dly_set,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              mute
);
   localparam int FILL_W = ADDR_W + 1;
   localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(DEPTH - 1);
   localparam logic [FILL_W-1:0] FULL   = FILL_W'(DEPTH);
   localparam bit                IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [ADDR_W-1:0] wptr, dly_q, wnext, rd_c, dly_cl;
   logic [FILL_W-1:0] filled;

   assign dly_cl = (dly_set > LAST) ? LAST : dly_set;

   generate
      if (IS_POW2) begin : g_pow2
         always_comb begin
            wnext = wptr + 1'b1;
            rd_c  = wptr - dly_q;
         end
      end else begin : g_mod
         logic [FILL_W-1:0] wrapped;
         always_comb begin
            wnext   = (wptr == LAST) ? '0 : wptr + 1'b1;
            wrapped = {1'b0, wptr} + FULL - {1'b0, dly_q};
            rd_c    = (wptr >= dly_q) ? (wptr - dly_q) : wrapped[ADDR_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr   <= '0;
         dly_q  <= '0;
         filled <= '0;
      end else begin
         if (start) dly_q <= dly_cl;
         if (adv) begin
            wptr <= wnext;
            if (filled != FULL) filled <= filled + 1'b1;
         end
      end
   end

   assign wr_addr = wptr;
   assign rd_addr = rd_c;
   assign mute    = filled < {1'b0, dly_q};

   // R9
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_addr <= LAST);
   // R9
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_addr <= LAST);
   // R6
   fill_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filled >= $past(filled));
   // R7
   dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> $stable(dly_q));
endmodule

// File: rtl/audio_delay_sram.sv
module audio_delay_sram #(
   parameter int DEPTH    = 262144,
   parameter int DATA_W   = 16,
   parameter int WE_CYC   = 2,
   parameter int TURN_CYC = 1,
   parameter int RD_CYC   = 2,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_in,
   input  logic [ADDR_W-1:0] dly_set,
   output logic [DATA_W-1:0] out_sample,
   output logic              out_valid,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   inout  wire  [DATA_W-1:0] sram_dq
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (WE_CYC < 1 || RD_CYC < 1) begin : g_bad_strobe
         $error("WE_CYC and RD_CYC must be at least 1");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("TURN_CYC must be at least 1");
      end
   endgenerate

   logic start, cap, drive_en, sel_rd, mute;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wdata_q, out_q;
   logic              vld_q;

   adly_seq #(.WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC), .RD_CYC(RD_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .start(start), .cap(cap), .ce_n(sram_ce_n), .we_n(sram_we_n),
      .oe_n(sram_oe_n), .drive_en(drive_en), .sel_rd(sel_rd)
   );

   adly_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .start(start), .adv(cap),
      .dly_set(dly_set), .wr_addr(wr_addr), .rd_addr(rd_addr), .mute(mute)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         out_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         if (start) wdata_q <= smp_in;
         if (cap) out_q <= mute ? '0 : sram_dq;
         vld_q <= cap;
      end
   end

   assign sram_dq    = drive_en ? wdata_q : {DATA_W{1'bz}};
   assign sram_addr  = sel_rd ? rd_addr : wr_addr;
   assign out_sample = out_q;
   assign out_valid  = vld_q;

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R6
   mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mute)) |-> (out_sample == '0));
   // R5
   valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(!sram_oe_n) && sram_oe_n));
endmodule

// File: tb/audio_delay_sram_test.sv
module audio_delay_sram_test;
   localparam int DEPTH = 20;
   localparam int DW    = 16;
   localparam int AW    = $clog2(DEPTH);
   localparam int NSMP  = 140;

   logic clk = 0, rst_n = 0, smp_valid = 0;
   logic [DW-1:0] smp_in = '0;
   logic [AW-1:0] dly_set = '0;
   logic [DW-1:0] out_sample;
   logic out_valid;
   logic [AW-1:0] sram_addr;
   logic sram_ce_n, sram_we_n, sram_oe_n;
   wire  [DW-1:0] sram_dq;
   logic [DW-1:0] mem [0:DEPTH-1];

   int total = 0, bad = 0;

   always #2 clk = ~clk;

   audio_delay_sram #(.DEPTH(DEPTH), .DATA_W(DW), .WE_CYC(2), .TURN_CYC(1), .RD_CYC(2)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
      .dly_set(dly_set), .out_sample(out_sample), .out_valid(out_valid),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
   );

   assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n && int'(sram_addr) < DEPTH)
                    ? mem[sram_addr] : {DW{1'bz}};

   always @(posedge sram_we_n)
      if (sram_ce_n == 1'b0 && int'(sram_addr) < DEPTH) mem[sram_addr] <= sram_dq;

   function automatic logic [DW-1:0] word_of(input int n);
      return DW'(n * 263 + 17) ^ 16'h5A00;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_sample(input int n, input int dset, input int deff, input bit extra);
      int exp_w, exp_r, wcnt, ocnt, last_we, first_oe, k;
      bit waddr_ok, wdata_ok, raddr_ok, both_low, got;
      int act_w, act_r;
      logic [DW-1:0] exp_o;
      exp_w = n % DEPTH;
      exp_r = ((n - deff) % DEPTH + DEPTH) % DEPTH;
      exp_o = (n >= deff) ? word_of(n - deff) : '0;
      wcnt = 0; ocnt = 0; last_we = -1; first_oe = -1;
      waddr_ok = 1; wdata_ok = 1; raddr_ok = 1; both_low = 0; got = 0;
      act_w = exp_w; act_r = exp_r;
      @(negedge clk);
      dly_set = AW'(dset); smp_in = word_of(n); smp_valid = 1;
      @(negedge clk);
      smp_valid = 0;
      dly_set = AW'(dset) ^ AW'(5'h15);
      for (k = 1; k < 24 && !got; k++) begin
         if (!sram_we_n) begin
            wcnt++; last_we = k;
            if (int'(sram_addr) != exp_w) begin waddr_ok = 0; act_w = int'(sram_addr); end
            if (sram_dq !== word_of(n)) wdata_ok = 0;
         end
         if (!sram_oe_n) begin
            ocnt++;
            if (first_oe < 0) first_oe = k;
            if (int'(sram_addr) != exp_r) begin raddr_ok = 0; act_r = int'(sram_addr); end
         end
         if (!sram_we_n && !sram_oe_n) both_low = 1;
         if (out_valid) begin
            got = 1;
            // R5 R6 delayed word or muted zero
            chk(out_sample == exp_o, "R5 R6 output word", int'(out_sample), int'(exp_o));
         end
         if (extra && k == 3) begin smp_valid = 1; smp_in = 16'hDEAD; end
         if (extra && k == 4) smp_valid = 0;
         @(negedge clk);
      end
      chk(got, "R5 valid pulse seen", int'(got), 1);
      chk(!out_valid, "R5 valid lasts one cycle", int'(out_valid), 0);
      chk(waddr_ok, "R2 R9 write address", act_w, exp_w);
      chk(wdata_ok, "R2 write data on bus", 0, 1);
      chk(wcnt == 2, "R2 write strobe width", wcnt, 2);
      chk(raddr_ok, "R3 R7 read address", act_r, exp_r);
      chk(ocnt == 2, "R3 read strobe width", ocnt, 2);
      chk(!both_low && (first_oe - last_we - 1) >= 2, "R4 turnaround gap",
          first_oe - last_we - 1, 2);
   endtask

   initial begin
      #(4 * 200000);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 held in reset
      chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes idle in reset", 0, 1);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R1 after release
      chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes idle after reset", 0, 1);
      chk(!out_valid && out_sample == '0, "R1 output cleared", int'(out_sample), 0);
      for (int n = 0; n < NSMP; n++) begin
         int d, ds;
         if (n < 25) d = 5;
         else if (n < 50) d = 0;
         else if (n < 80) d = 19;
         else if (n < 100) d = 1;
         else if (n < 135) d = 12;
         else d = 19;
         ds = (n >= 135) ? 31 : d;
         // R8 stray strobes on every seventh sample; R7 clamp near the end
         run_sample(n, ds, d, (n % 7) == 3);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule